// File: doc/BRIEF.md
# Progressive Video Frame Line Sequencer

This block produces the line-level timing of a single progressive video frame for a small home-computer style display. A column counter divides the CPU clock into lines. A line counter then steps through six phases: frame sync, an upper border, a first alignment line, the picture lines, a lower border and a second alignment line. The block drives horizontal and vertical sync, a picture flag, a border flag, a phase code and the current line number. Character fetching and pixel shifting sit downstream and are not part of it.

A one-bit region input picks the length of the upper border: 55 lines for 50 Hz sets or 31 lines for 60 Hz sets. The block samples this input only when a new frame starts, so a frame's length never changes partway through. Every output comes from a register and shows the counter position of the previous clock.

Top module: `vfs_frame_seq`

## Requirements
- R1: While `rst` is high, on every clock edge all outputs go to 0. This includes `line_idx_o` = 0 and `phase_o` = 0. The region input is captured during reset and sets the border length of the first frame.
- R2: A line lasts `CLKS_PER_LINE` clocks (207 by default). `line_idx_o` rises by exactly one at each line boundary and never changes at any other time. The first output sample after reset belongs to column 0 of line 0.
- R3: `hsync_o` is high for the first `HSYNC_CLKS` clocks (default 16) of every line outside vertical sync, and low for the rest of the line.
- R4: `vsync_o` is high for exactly lines 0 to 5 of each frame, and `hsync_o` stays low during those lines.
- R5: Lines 6 to 60 form the upper border when region = 0 (55 lines). Lines 6 to 36 form it when region = 1 (31 lines). `margin_o` is high throughout the upper border.
- R6: Exactly one alignment line follows the upper border. On that line `vsync_o`, `active_o` and `margin_o` are all low.
- R7: `active_o` is high for exactly 194 consecutive lines, starting on the line after the first alignment line, and is low everywhere else.
- R8: The picture is followed by 55 lower-border lines with `margin_o` high, then one alignment line with no flags high. A frame therefore has 312 lines (region 0) or 288 lines (region 1). `line_idx_o` then returns to 0 as vertical sync starts again.
- R9: The region input is sampled only on the clock at which the last column of the last line wraps to line 0. A change at any other time has no effect on the current frame.
- R10: `phase_o` encodes the phase as follows: 0 vertical sync, 1 upper border, 2 first alignment line, 3 picture, 4 lower border, 5 second alignment line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| region_sel_i | input | 1 | Border length select: 0 gives 55 lines, 1 gives 31 lines |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| active_o | output | 1 | Picture line flag |
| margin_o | output | 1 | Upper or lower border line flag |
| phase_o | output | 3 | Phase code per R10 |
| line_idx_o | output | LINE_W (9) | Line number within the frame |

## Verification
Three events land on the same clock edge: the end of the last line of a frame, the return of the line number to 0 with vertical sync starting, and the latch of the region input. The bench changes the region input one clock before that wrap edge. It then expects the next frame to use the new border length, and compares every output on every clock of that frame against an independent model. A second change is made inside the next frame's upper border. That frame must keep its latched length, and the change must only show up in the frame after it.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [2:0] {
    PH_VSYNC  = 3'd0,
    PH_TOP    = 3'd1,
    PH_SYNC_A = 3'd2,
    PH_ACTIVE = 3'd3,
    PH_BOTTOM = 3'd4,
    PH_SYNC_B = 3'd5
  } phase_e;
endpackage

// File: rtl/vfs_col_counter.sv
module vfs_col_counter #(
  parameter int CLKS_PER_LINE = 207,
  localparam int COL_W = $clog2(CLKS_PER_LINE)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [COL_W-1:0] col_o,
  output logic             line_end_o
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(CLKS_PER_LINE - 1);

  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk) begin
    if (rst)                  col_q <= '0;
    else if (col_q == LAST_COL) col_q <= '0;
    else                      col_q <= col_q + 1'b1;
  end

  assign col_o      = col_q;
  assign line_end_o = (col_q == LAST_COL);
endmodule

// File: rtl/vfs_line_tracker.sv
module vfs_line_tracker
  import vfs_pkg::*;
#(
  parameter int VSYNC_LINES  = 6,
  parameter int TOP_LINES_50 = 55,
  parameter int TOP_LINES_60 = 31,
  parameter int SYNC_LINES   = 1,
  parameter int ACTIVE_LINES = 194,
  parameter int BOTTOM_LINES = 55,
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_end_i,
  input  logic              region_sel_i,
  output logic [LINE_W-1:0] line_o,
  output phase_e            phase_o
);
  // phase boundaries (exclusive ends) for each region
  localparam int TOP_END_50 = VSYNC_LINES + TOP_LINES_50;
  localparam int TOP_END_60 = VSYNC_LINES + TOP_LINES_60;

  localparam logic [LINE_W-1:0] VS_END = LINE_W'(VSYNC_LINES);

  logic              region_q;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] top_end, sync_a_end, act_end, bot_end, last_line;

  always_comb begin
    top_end    = region_q ? LINE_W'(TOP_END_60) : LINE_W'(TOP_END_50);
    sync_a_end = top_end + LINE_W'(SYNC_LINES);
    act_end    = sync_a_end + LINE_W'(ACTIVE_LINES);
    bot_end    = act_end + LINE_W'(BOTTOM_LINES);
    last_line  = bot_end + LINE_W'(SYNC_LINES - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= '0;
      region_q <= region_sel_i;
    end else if (line_end_i) begin
      if (line_q == last_line) begin
        line_q   <= '0;
        region_q <= region_sel_i;
      end else begin
        line_q <= line_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (line_q < VS_END)          phase_o = PH_VSYNC;
    else if (line_q < top_end)    phase_o = PH_TOP;
    else if (line_q < sync_a_end) phase_o = PH_SYNC_A;
    else if (line_q < act_end)    phase_o = PH_ACTIVE;
    else if (line_q < bot_end)    phase_o = PH_BOTTOM;
    else                          phase_o = PH_SYNC_B;
  end

  assign line_o = line_q;
endmodule

// File: rtl/vfs_out_stage.sv
module vfs_out_stage
  import vfs_pkg::*;
#(
  parameter int COL_W      = 8,
  parameter int LINE_W     = 9,
  parameter int HSYNC_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COL_W-1:0]  col_i,
  input  logic [LINE_W-1:0] line_i,
  input  phase_e            phase_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              active_o,
  output logic              margin_o,
  output logic [2:0]        phase_o,
  output logic [LINE_W-1:0] line_idx_o
);
  localparam logic [COL_W-1:0] HS_END = COL_W'(HSYNC_CLKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      active_o   <= 1'b0;
      margin_o   <= 1'b0;
      phase_o    <= 3'd0;
      line_idx_o <= '0;
    end else begin
      hsync_o    <= (col_i < HS_END) && (phase_i != PH_VSYNC);
      vsync_o    <= (phase_i == PH_VSYNC);
      active_o   <= (phase_i == PH_ACTIVE);
      margin_o   <= (phase_i == PH_TOP) || (phase_i == PH_BOTTOM);
      phase_o    <= phase_i;
      line_idx_o <= line_i;
    end
  end
endmodule

// File: rtl/vfs_frame_seq.sv
module vfs_frame_seq
  import vfs_pkg::*;
#(
  parameter int CLKS_PER_LINE = 207,
  parameter int HSYNC_CLKS    = 16,
  parameter int VSYNC_LINES   = 6,
  parameter int TOP_LINES_50  = 55,
  parameter int TOP_LINES_60  = 31,
  parameter int SYNC_LINES    = 1,
  parameter int ACTIVE_LINES  = 194,
  parameter int BOTTOM_LINES  = 55,
  localparam int MAX_TOP = (TOP_LINES_50 > TOP_LINES_60) ? TOP_LINES_50 : TOP_LINES_60,
  localparam int MAX_LINES = VSYNC_LINES + MAX_TOP + 2 * SYNC_LINES + ACTIVE_LINES + BOTTOM_LINES,
  localparam int LINE_W = $clog2(MAX_LINES),
  localparam int COL_W = $clog2(CLKS_PER_LINE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              region_sel_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              active_o,
  output logic              margin_o,
  output logic [2:0]        phase_o,
  output logic [LINE_W-1:0] line_idx_o
);
  logic [COL_W-1:0]  col;
  logic              line_end;
  logic [LINE_W-1:0] line;
  phase_e            phase;

  vfs_col_counter #(.CLKS_PER_LINE(CLKS_PER_LINE)) col_i (
    .clk(clk), .rst(rst), .col_o(col), .line_end_o(line_end)
  );

  vfs_line_tracker #(
    .VSYNC_LINES(VSYNC_LINES), .TOP_LINES_50(TOP_LINES_50),
    .TOP_LINES_60(TOP_LINES_60), .SYNC_LINES(SYNC_LINES),
    .ACTIVE_LINES(ACTIVE_LINES), .BOTTOM_LINES(BOTTOM_LINES),
    .LINE_W(LINE_W)
  ) line_i (
    .clk(clk), .rst(rst), .line_end_i(line_end),
    .region_sel_i(region_sel_i), .line_o(line), .phase_o(phase)
  );

  vfs_out_stage #(.COL_W(COL_W), .LINE_W(LINE_W), .HSYNC_CLKS(HSYNC_CLKS)) out_i (
    .clk(clk), .rst(rst), .col_i(col), .line_i(line), .phase_i(phase),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .active_o(active_o),
    .margin_o(margin_o), .phase_o(phase_o), .line_idx_o(line_idx_o)
  );
endmodule

// File: rtl/vfs_frame_seq_chk.sv
module vfs_frame_seq_chk #(
  parameter int LINE_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              active_o,
  input logic              margin_o,
  input logic [2:0]        phase_o,
  input logic [LINE_W-1:0] line_idx_o
);
  // R4: no horizontal sync while vertical sync is high
  a_r4_vsync_no_hsync: assert property (@(posedge clk) disable iff (rst)
    vsync_o |-> !hsync_o);

  // R7: picture and border flags never overlap
  a_r7_active_not_margin: assert property (@(posedge clk) disable iff (rst)
    active_o |-> !margin_o);

  // R2: line number only steps by one or wraps to zero
  a_r2_line_step: assert property (@(posedge clk) disable iff (rst)
    (line_idx_o != $past(line_idx_o)) |->
      (line_idx_o == $past(line_idx_o) + 1'b1) || (line_idx_o == '0));

  // R8: wrapping to line zero begins vertical sync
  a_r8_wrap_vsync: assert property (@(posedge clk) disable iff (rst)
    ((line_idx_o == '0) && ($past(line_idx_o) != '0)) |-> vsync_o);

  // R3: horizontal sync starts only on the first clock of a line
  a_r3_hsync_line_start: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_o) |-> (line_idx_o != $past(line_idx_o)));

  // R10: phase code stays in range and matches the flags
  a_r10_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase_o <= 3'd5);
  a_r10_active_phase: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (phase_o == 3'd3));
  a_r5_margin_phase: assert property (@(posedge clk) disable iff (rst)
    margin_o |-> (phase_o == 3'd1 || phase_o == 3'd4));
endmodule

bind vfs_frame_seq vfs_frame_seq_chk #(.LINE_W(LINE_W)) chk_i (
  .clk(clk), .rst(rst), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .active_o(active_o), .margin_o(margin_o), .phase_o(phase_o),
  .line_idx_o(line_idx_o)
);

// File: tb/vfs_frame_seq_tb_top.sv
`timescale 1ns/1ps
module vfs_frame_seq_tb_top;
  localparam int CPL = 24;
  localparam int HS  = 5;

  typedef struct packed {
    logic       hs;
    logic       vs;
    logic       act;
    logic       mar;
    logic [2:0] ph;
    logic [8:0] line;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       region_sel = 1'b0;
  logic       hsync, vsync, active, margin;
  logic [2:0] phase;
  logic [8:0] line_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  vfs_frame_seq #(.CLKS_PER_LINE(CPL), .HSYNC_CLKS(HS)) dut_i (
    .clk(clk), .rst(rst), .region_sel_i(region_sel),
    .hsync_o(hsync), .vsync_o(vsync), .active_o(active),
    .margin_o(margin), .phase_o(phase), .line_idx_o(line_idx)
  );

  function automatic int frame_lines(input logic r);
    return 6 + (r ? 31 : 55) + 1 + 194 + 55 + 1;
  endfunction

  function automatic exp_t model(input logic r, input int l, input int c);
    exp_t e;
    int top_end = 6 + (r ? 31 : 55);
    int act_beg = top_end + 1;
    int act_end = act_beg + 194;
    int bot_end = act_end + 55;
    if (l < 6)            e.ph = 3'd0;
    else if (l < top_end) e.ph = 3'd1;
    else if (l < act_beg) e.ph = 3'd2;
    else if (l < act_end) e.ph = 3'd3;
    else if (l < bot_end) e.ph = 3'd4;
    else                  e.ph = 3'd5;
    e.vs   = (e.ph == 3'd0);
    e.hs   = (c < HS) && !e.vs;
    e.act  = (e.ph == 3'd3);
    e.mar  = (e.ph == 3'd1) || (e.ph == 3'd4);
    e.line = 9'(l);
    return e;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp_v);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // scoreboard monitor: compares one expected item per clock
  always @(negedge clk) begin
    if (!done && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R3", "hsync", int'(hsync), int'(e.hs));
      chk("R4", "vsync", int'(vsync), int'(e.vs));
      chk("R7", "active", int'(active), int'(e.act));
      chk("R5 R6 R8", "margin", int'(margin), int'(e.mar));
      chk("R10", "phase", int'(phase), int'(e.ph));
      chk("R2 R8 R9", "line", int'(line_idx), int'(e.line));
    end
  end

  // driver: one expected item per clock; optional region change at flip_at
  task automatic run_frame(input logic r, input int flip_at, input logic flip_val);
    int total = frame_lines(r);
    for (int l = 0; l < total; l++) begin
      for (int c = 0; c < CPL; c++) begin
        @(posedge clk);
        exp_q.push_back(model(r, l, c));
        if (l * CPL + c == flip_at) begin
          #1 region_sel = flip_val;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1: outputs held at zero during reset
    repeat (3) begin
      @(negedge clk);
      chk("R1", "hsync", int'(hsync), 0);
      chk("R1", "vsync", int'(vsync), 0);
      chk("R1", "active", int'(active), 0);
      chk("R1", "margin", int'(margin), 0);
      chk("R1", "phase", int'(phase), 0);
      chk("R1", "line", int'(line_idx), 0);
    end
    rst = 1'b0;
    // Frame 1 (region 0): region changes one clock before the wrap edge (R9 coincidence)
    run_frame(1'b0, frame_lines(1'b0) * CPL - 2, 1'b1);
    // Frame 2 (region 1): change inside upper border is ignored for this frame (R9)
    run_frame(1'b1, 10 * CPL + 3, 1'b0);
    // Frame 3 (region 0): change during picture lines is ignored (R9)
    run_frame(1'b0, 120 * CPL + 7, 1'b1);
    repeat (2) @(negedge clk);
    chk("R9", "queue drained", exp_q.size(), 0);
    done = 1;
    summary();
  end
endmodule